// File: doc/BRIEF.md
# Movable Four-Word Register Overlay

This block places four hidden 32-bit words over any aligned group of four addresses in a processor's register file. Once a window base has been loaded, reads that land in the window return the hidden words in place of the RAM contents. Writes that land in the window go to both the hidden word and the RAM word beneath it. A wide 128-bit fetch from shared memory reloads all four hidden words at once. It never disturbs the RAM.

The wide fetch is tracked through a fixed-latency pipeline. The new contents appear in the window a set number of cycles after the fetch is issued, and until then reads still see the previous contents. The register-file RAM sits outside the block. The block receives the RAM's read data for the current read address and forwards every register write to the RAM write port.

Top module: `quad_window_overlay`

## Requirements
- R1: After reset the window is disabled, and `rd_data` equals `rd_ram_data` for every address until the first map command.
- R2: A map command with `map_valid`=1 loads a window covering the four addresses whose upper bits equal `map_base[ADDR_W-1:2]`; the low two bits of `map_base` are ignored. A read inside the window returns the hidden word selected by `rd_addr[1:0]`.
- R3: A new base takes effect at the clock edge that samples `map_valid`. During the command cycle, reads still use the old window. From the next cycle, addresses that have left the window return RAM data. The hidden words keep their contents across a remap.
- R4: The wide load fills the hidden words by lane: the word at lane offset k (address bits [1:0] = k) receives `load_data[32k+31:32k]`.
- R5: If `load_issue` is sampled high in cycle c, the loaded words are read back from cycle c+LOAD_LAT on (default 5). Cycles c+1 to c+LOAD_LAT-1 still return the previous contents.
- R6: A write (`wr_en`) inside the window updates the selected hidden word, and the same address, data and enable appear on the RAM write port in that cycle.
- R7: A wide load never drives the RAM: `ram_we` is high only in cycles where `wr_en` is high, and RAM words under the window keep their old values after a load.
- R8: A write outside the window reaches the RAM only, and all four hidden words are left unchanged.
- R9: If a write and a load completion reach the same hidden word at the same edge, the hidden word takes the load data, and the RAM still takes the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_valid | input | 1 | Load a new window base |
| map_base | input | ADDR_W | New window base; bits [1:0] are ignored |
| load_issue | input | 1 | Issue a wide load of the four hidden words |
| load_data | input | 4*DATA_W | Wide load data, lowest lane in the lowest bits |
| rd_addr | input | ADDR_W | Register-file read address |
| rd_ram_data | input | DATA_W | RAM contents at `rd_addr` |
| rd_data | output | DATA_W | Read result with the overlay applied |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |

## Verification
Words are loaded with a distinct value in every lane, so a swapped or shifted lane order shows up at once. Reads are made on every cycle between the issue and the completion, so a latency that is one cycle off in either direction is caught. The window is then moved away, back over RAM, and to an unaligned base. This shows whether each value came from the hidden word or from the RAM beneath it, which is how write-through is separated from a load that wrongly writes the RAM. A write aimed at the same lane and the same edge as a load completion settles which value the hidden word keeps. The RAM's copy is checked afterwards.

// File: rtl/quad_ovl_pkg.sv
package quad_ovl_pkg;
    localparam int LANES     = 4;
    localparam int LANE_BITS = $clog2(LANES);
    typedef logic [LANE_BITS-1:0] lane_t;
endpackage

// File: rtl/quad_load_pipe.sv
module quad_load_pipe #(
    parameter int LOAD_LAT = 5,
    parameter int LW       = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [LW-1:0] issue_data,
    output logic          done,
    output logic [LW-1:0] done_data
);
    // Stage count excludes the final register write into the word bank.
    localparam int DEPTH = LOAD_LAT - 1;

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][LW-1:0] dat;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.vld[0] = issue;
        st_d.dat[0] = issue_data;
        for (int s = 1; s < DEPTH; s++) begin
            st_d.vld[s] = st_q.vld[s-1];
            st_d.dat[s] = st_q.dat[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.vld[DEPTH-1];
    assign done_data = st_q.dat[DEPTH-1];
endmodule

// File: rtl/quad_word_bank.sv
module quad_word_bank
    import quad_ovl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_hit,
    input  lane_t                        wr_lane,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         ld_en,
    input  logic [LANES-1:0][DATA_W-1:0] ld_data,
    output logic [LANES-1:0][DATA_W-1:0] words
);
    typedef struct packed {
        logic [LANES-1:0][DATA_W-1:0] w;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < LANES; k++) begin
            if (ld_en) begin
                st_d.w[k] = ld_data[k];          // load wins on collision
            end else if (wr_hit && (wr_lane == lane_t'(k))) begin
                st_d.w[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.w;
endmodule

// File: rtl/quad_window_overlay.sv
module quad_window_overlay
    import quad_ovl_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32,
    parameter int LOAD_LAT = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    map_valid,
    input  logic [ADDR_W-1:0]       map_base,
    input  logic                    load_issue,
    input  logic [4*DATA_W-1:0]     load_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [DATA_W-1:0]       rd_ram_data,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    ram_we,
    output logic [ADDR_W-1:0]       ram_waddr,
    output logic [DATA_W-1:0]       ram_wdata
);
    localparam int BLK_W = ADDR_W - LANE_BITS;
    localparam int LW    = LANES * DATA_W;

    typedef struct packed {
        logic             win_vld;
        logic [BLK_W-1:0] base_blk;
    } win_t;

    win_t win_d, win_q;
    logic win_vld_q;
    logic [BLK_W-1:0] base_blk_q;
    logic ld_done;
    logic [LW-1:0] ld_word;
    logic [LANES-1:0][DATA_W-1:0] words;
    logic rd_hit, wr_hit;

    always_comb begin
        win_d = win_q;
        if (map_valid) begin
            win_d.win_vld  = 1'b1;
            win_d.base_blk = map_base[ADDR_W-1:LANE_BITS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign win_vld_q  = win_q.win_vld;
    assign base_blk_q = win_q.base_blk;

    assign rd_hit = win_vld_q && (rd_addr[ADDR_W-1:LANE_BITS] == base_blk_q);
    assign wr_hit = wr_en && win_vld_q && (wr_addr[ADDR_W-1:LANE_BITS] == base_blk_q);

    quad_load_pipe #(.LOAD_LAT(LOAD_LAT), .LW(LW)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (load_issue),
        .issue_data (load_data),
        .done       (ld_done),
        .done_data  (ld_word)
    );

    quad_word_bank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_lane (lane_t'(wr_addr[LANE_BITS-1:0])),
        .wr_data (wr_data),
        .ld_en   (ld_done),
        .ld_data (ld_word),
        .words   (words)
    );

    always_comb begin
        rd_data = rd_ram_data;
        if (rd_hit) begin
            rd_data = words[rd_addr[LANE_BITS-1:0]];
        end
    end

    assign ram_we    = wr_en;
    assign ram_waddr = wr_addr;
    assign ram_wdata = wr_data;
endmodule

// File: rtl/quad_window_checker.sv
module quad_window_checker #(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32,
    parameter int LOAD_LAT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              map_valid,
    input logic              load_issue,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_ram_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              ram_we,
    input logic              win_vld_q,
    input logic [ADDR_W-3:0] base_blk_q,
    input logic              ld_done
);
    localparam int DEPTH = LOAD_LAT - 1;
    logic [DEPTH-1:0] hist;

    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= (hist << 1) | DEPTH'(load_issue);
    end

    logic wr_in_win;
    assign wr_in_win = wr_en && win_vld_q && (wr_addr[ADDR_W-1:2] == base_blk_q);

    assert_hidden_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !win_vld_q |-> rd_data == rd_ram_data);

    assert_remap_vacate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |=> (!($past(win_vld_q) && rd_addr[ADDR_W-1:2] == $past(base_blk_q)
                         && rd_addr[ADDR_W-1:2] != base_blk_q) || rd_data == rd_ram_data));

    assert_load_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done == hist[DEPTH-1]);

    assert_write_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_in_win && !ld_done && !map_valid) |=>
            (rd_addr != $past(wr_addr) || rd_data == $past(wr_data)));

    assert_load_no_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done && !wr_en) |-> !ram_we);
endmodule

bind quad_window_overlay quad_window_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOAD_LAT(LOAD_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .map_valid(map_valid), .load_issue(load_issue),
    .rd_addr(rd_addr), .rd_ram_data(rd_ram_data), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ram_we(ram_we),
    .win_vld_q(win_vld_q), .base_blk_q(base_blk_q), .ld_done(ld_done)
);

// File: tb/tb_quad_window_overlay.sv
`timescale 1ns/1ps
module tb_quad_window_overlay;
    localparam int AW  = 9;
    localparam int DW  = 32;
    localparam int LAT = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic map_valid = 0;
    logic [AW-1:0] map_base = '0;
    logic load_issue = 0;
    logic [4*DW-1:0] load_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_ram_data;
    logic [DW-1:0] rd_data;
    logic wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic ram_we;
    logic [AW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata;

    int checks = 0, fails = 0, stray_we = 0;
    logic done = 0;

    always #2 clk = ~clk;

    quad_window_overlay #(.ADDR_W(AW), .DATA_W(DW), .LOAD_LAT(LAT)) dut (.*);

    logic [DW-1:0] bram [1<<AW];
    function automatic logic [DW-1:0] init_val(input int a);
        return 32'hC0DE0000 | a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1<<AW); i++) bram[i] <= init_val(i);
        end else begin
            if (ram_we) bram[ram_waddr] <= ram_wdata;
            if (ram_we && !wr_en) stray_we++;
        end
    end
    assign rd_ram_data = bram[rd_addr];

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input int a, input logic [DW-1:0] exp);
        rd_addr = AW'(a);
        #0.2;
        check(req, rd_data, exp);
    endtask

    task automatic do_map(input int b);
        map_valid = 1; map_base = AW'(b); step; map_valid = 0;
    endtask

    task automatic do_load(input logic [4*DW-1:0] d);
        load_issue = 1; load_data = d; step; load_issue = 0;
        for (int k = 1; k < LAT; k++) step;
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        wr_en = 1; wr_addr = AW'(a); wr_data = d; step; wr_en = 0;
    endtask

    localparam logic [4*DW-1:0] DA = {32'hA3A3A3A3, 32'hA2A2A2A2, 32'hA1A1A1A1, 32'hA0A0A0A0};
    localparam logic [4*DW-1:0] DB = {32'hB3B3B3B3, 32'hB2B2B2B2, 32'hB1B1B1B1, 32'hB0B0B0B0};
    localparam logic [4*DW-1:0] DC = {32'hC3C3C3C3, 32'hC2C2C2C2, 32'hC1C1C1C1, 32'hC0C0C0C0};

    task automatic t_reset;   // R1
        for (int a = 'h1E0; a < 'h1E4; a++) rd_chk("R1 hidden after reset", a, init_val(a));
        rd_chk("R1 hidden after reset", 0, init_val(0));
    endtask

    task automatic t_map_load;   // R2, R4
        do_map('h1E0);
        do_load(DA);
        for (int k = 0; k < 4; k++) rd_chk("R2/R4 lane order", 'h1E0 + k, DA[32*k +: 32]);
        rd_chk("R2 outside window", 'h1E4, init_val('h1E4));
    endtask

    task automatic t_latency;   // R5
        load_issue = 1; load_data = DB; step; load_issue = 0;
        for (int k = 1; k < LAT; k++) begin
            rd_chk("R5 old contents before latency", 'h1E3, DA[127:96]);
            step;
        end
        rd_chk("R5 new contents at latency", 'h1E3, DB[127:96]);
        rd_chk("R5 new contents at latency", 'h1E0, DB[31:0]);
    endtask

    task automatic t_write;   // R6
        do_write('h1E2, 32'h5EED0001);
        rd_chk("R6 write updates hidden word", 'h1E2, 32'h5EED0001);
        rd_chk("R6 neighbour untouched", 'h1E1, DB[63:32]);
    endtask

    task automatic t_remap;   // R3, R6, R7
        map_valid = 1; map_base = AW'('h100);
        rd_chk("R3 old window during map cycle", 'h1E1, DB[63:32]);
        step; map_valid = 0;
        rd_chk("R3/R7 vacated address shows untouched RAM", 'h1E1, init_val('h1E1));
        rd_chk("R7 RAM under load unchanged", 'h1E3, init_val('h1E3));
        rd_chk("R6 RAM received write", 'h1E2, 32'h5EED0001);
        rd_chk("R3 contents follow window", 'h100, DB[31:0]);
    endtask

    task automatic t_unaligned;   // R2
        do_map('h1E6);
        rd_chk("R2 unaligned base lane0", 'h1E4, DB[31:0]);
        rd_chk("R2 unaligned base lane2", 'h1E6, 32'h5EED0001);
        rd_chk("R2 unaligned base lane3", 'h1E7, DB[127:96]);
        rd_chk("R2 below window is RAM", 'h1E3, init_val('h1E3));
    endtask

    task automatic t_outside;   // R8
        do_write('h010, 32'h0DD00010);
        rd_chk("R8 outside write reaches RAM", 'h010, 32'h0DD00010);
        for (int k = 0; k < 4; k++)
            rd_chk("R8 hidden words unchanged", 'h1E4 + k, (k == 2) ? 32'h5EED0001 : DB[32*k +: 32]);
    endtask

    task automatic t_collide;   // R9
        load_issue = 1; load_data = DC; step; load_issue = 0;
        for (int k = 1; k < LAT - 1; k++) step;
        wr_en = 1; wr_addr = AW'('h1E5); wr_data = 32'h7777CAFE; step; wr_en = 0;
        rd_chk("R9 load wins hidden word", 'h1E5, DC[63:32]);
        rd_chk("R9 other lane loaded", 'h1E4, DC[31:0]);
        do_map('h000);
        rd_chk("R9 RAM still takes write", 'h1E5, 32'h7777CAFE);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step;
        rst_n = 1;
        step;
        t_reset;
        t_map_load;
        t_latency;
        t_write;
        t_remap;
        t_unaligned;
        t_outside;
        t_collide;
        checks++;
        if (stray_we != 0) begin
            fails++;
            $display("FAIL R7: actual %0d stray RAM writes expected 0", stray_we);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule